// File: doc/BRIEF.md
# Parallel Bus Transaction Monitor

This block watches the active-low framing and handshake lines of a shared parallel bus with initiator and target handshakes. It never drives the bus. On every clock it samples FRAME#, IRDY#, TRDY# and STOP#. It notices when a transaction opens and when it closes, and it decides which clocks finish a data phase and which clocks actually move a word. From those decisions it produces a busy indication, one-clock pulses for finished phases and moved words, a per-transaction word count, and four sticky flags for termination-rule violations.

The same rule decides phase completion for every phase: initiator ready together with either target ready or target stop. After stop has been seen in a transaction, initiator ready alone ends a phase. One of the flags catches a target that keeps supplying data after it has stopped. That case is a phase that finishes with stop and target ready both asserted, followed by target ready asserted again before the transaction closes. Every output is registered, so each output reflects the bus as it was sampled on the previous rising edge.

Top module: `bus_txn_monitor`

## Requirements
- R1: A synchronous active-high reset returns the monitor to idle. After reset, busy is 0, both pulses are 0, the word count is 0 and all error flags are 0. This holds even if errors were set before the reset.
- R2: A transaction opens on a sample with FRAME# low while the monitor is idle, and busy reads 1 from the next clock. The transaction closes on a sample with FRAME# and IRDY# both high, and busy reads 0 from the next clock. While idle, samples with FRAME# high are ignored, including samples with STOP# or TRDY# low.
- R3: The transfer pulse is 1 for exactly one clock after each in-transaction sample with IRDY# and TRDY# both low. The word count rises by one for each such sample. It restarts from zero when a new transaction opens and holds its value after the transaction closes.
- R4: The phase-done pulse is 1 for one clock after each in-transaction sample with IRDY# low and either TRDY# or STOP# low. Once STOP# has been sampled low in a transaction, IRDY# low alone finishes a phase.
- R5: A phase that finishes with FRAME# high is the final phase. If IRDY# is still sampled low on the next clock, the ready-linger flag is set.
- R6: A sample may have FRAME# low and IRDY# low with the phase not finished. If FRAME# is sampled high on the next clock, the early-frame-drop flag is set.
- R7: A phase may finish with STOP# and TRDY# both low. Any later sample of TRDY# low in the same transaction sets the target-extension flag.
- R8: Once STOP# has been sampled low in a transaction, a sample with STOP# high sets the stop-release flag while FRAME# or IRDY# is still low.
- R9: Error flags are sticky. They stay set across idle clocks and later clean transactions, and a one-clock pulse on err_clr clears them on the next clock.
- R10: The word count saturates at its all-ones value (255 with the default width). It does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| err_clr | input | 1 | Clears all sticky error flags, active high |
| frame_n | input | 1 | Sampled FRAME#, active low |
| irdy_n | input | 1 | Sampled IRDY#, active low |
| trdy_n | input | 1 | Sampled TRDY#, active low |
| stop_n | input | 1 | Sampled STOP#, active low |
| busy | output | 1 | A transaction is in progress |
| xfer_pulse | output | 1 | A word moved on the previous clock |
| phase_done | output | 1 | A data phase finished on the previous clock |
| xfer_count | output | CNT_W | Words moved in the current or last transaction |
| err_irdy_linger | output | 1 | Sticky: IRDY# held after the final phase |
| err_frame_drop | output | 1 | Sticky: FRAME# released during an unfinished phase |
| err_trdy_extend | output | 1 | Sticky: TRDY# asserted after a stop-with-data phase |
| err_stop_drop | output | 1 | Sticky: STOP# released before the transaction closed |

## Verification
The bench replays a clean four-word burst, a disconnect in which the target stops without data, and the overlapped case where a target asserts TRDY# again after a phase that ended with stop and data. A design that checked STOP# before TRDY# would drop the word on that last phase. A design that ignored the extension rule would leave its flag clear. A stop-release case checks that IRDY# alone still ends a phase once stop has been seen, while the release is flagged; a tracker that needs TRDY# again would miss that phase-done pulse. Other tests target an off-by-one count at the 255 limit, a count that carries over from one transaction to the next instead of restarting, and flags that clear themselves when the bus goes idle.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;

  // One clock's worth of bus lines, already turned to positive logic.
  typedef struct packed {
    logic frame;
    logic irdy;
    logic trdy;
    logic stop;
  } bus_smp_t;

  // Sticky error indices.
  localparam int N_ERR      = 4;
  localparam int ERR_LINGER = 0;
  localparam int ERR_DROP   = 1;
  localparam int ERR_EXTEND = 2;
  localparam int ERR_STOPRL = 3;

  function automatic bus_smp_t from_pins(input logic fn, input logic in_n,
                                         input logic tn, input logic sn);
    bus_smp_t b;
    b.frame = ~fn;
    b.irdy  = ~in_n;
    b.trdy  = ~tn;
    b.stop  = ~sn;
    return b;
  endfunction

  // A phase ends on initiator ready plus target ready or stop.
  // After stop has been seen, initiator ready alone is enough.
  function automatic logic phase_complete(input bus_smp_t b, input logic stop_seen);
    return b.irdy & (b.trdy | b.stop | stop_seen);
  endfunction

  // A word moves only with both ready lines asserted.
  function automatic logic data_moved(input bus_smp_t b);
    return b.irdy & b.trdy;
  endfunction

endpackage

// File: rtl/bus_mon_tracker.sv
module bus_mon_tracker
  import bus_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  bus_smp_t         smp,
  output logic             busy_q,
  output logic             xfer_q,
  output logic             done_q,
  output logic             ev_start,
  output logic             ev_xfer,
  output logic [N_ERR-1:0] ev_err
);

  logic stop_seen_q;   // stop observed in this transaction
  logic both_q;        // a phase finished with stop and target ready
  logic last_q;        // final phase finished on the previous clock
  logic commit_q;      // frame+irdy asserted with phase unfinished

  logic in_txn;
  logic ev_done;
  logic keep;

  assign ev_start = ~busy_q & smp.frame;
  assign in_txn   = busy_q | ev_start;
  assign ev_done  = in_txn & phase_complete(smp, stop_seen_q);
  assign ev_xfer  = in_txn & data_moved(smp);
  assign keep     = ev_start | (busy_q & (smp.frame | smp.irdy));

  always_comb begin
    ev_err             = '0;
    ev_err[ERR_LINGER] = busy_q & last_q & smp.irdy;
    ev_err[ERR_DROP]   = busy_q & commit_q & ~smp.frame;
    ev_err[ERR_EXTEND] = busy_q & both_q & smp.trdy;
    ev_err[ERR_STOPRL] = busy_q & stop_seen_q & ~smp.stop & (smp.frame | smp.irdy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      xfer_q      <= 1'b0;
      done_q      <= 1'b0;
      stop_seen_q <= 1'b0;
      both_q      <= 1'b0;
      last_q      <= 1'b0;
      commit_q    <= 1'b0;
    end else begin
      busy_q      <= keep;
      xfer_q      <= ev_xfer;
      done_q      <= ev_done;
      stop_seen_q <= keep & (stop_seen_q | (in_txn & smp.stop));
      both_q      <= keep & (both_q | (ev_done & smp.stop & smp.trdy));
      last_q      <= in_txn & ev_done & ~smp.frame;
      commit_q    <= in_txn & smp.frame & smp.irdy & ~ev_done;
    end
  end

endmodule

// File: rtl/bus_mon_errors.sv
module bus_mon_errors
  import bus_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [N_ERR-1:0] ev_err,
  output logic [N_ERR-1:0] err_q
);

  for (genvar g = 0; g < N_ERR; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) err_q[g] <= 1'b0;
      else     err_q[g] <= (err_q[g] & ~clr) | ev_err[g];
    end
  end

endmodule

// File: rtl/bus_mon_counter.sv
module bus_mon_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             xfer,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (start) cnt_q <= {{(CNT_W-1){1'b0}}, xfer};
    else if (xfer)  cnt_q <= sat_inc(cnt_q);
  end

endmodule

// File: rtl/bus_txn_monitor.sv
module bus_txn_monitor
  import bus_mon_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_clr,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             stop_n,
  output logic             busy,
  output logic             xfer_pulse,
  output logic             phase_done,
  output logic [CNT_W-1:0] xfer_count,
  output logic             err_irdy_linger,
  output logic             err_frame_drop,
  output logic             err_trdy_extend,
  output logic             err_stop_drop
);

  bus_smp_t         smp;
  logic             ev_start;
  logic             ev_xfer;
  logic [N_ERR-1:0] ev_err;
  logic [N_ERR-1:0] err_vec;

  assign smp = from_pins(frame_n, irdy_n, trdy_n, stop_n);

  bus_mon_tracker u_trk (
    .clk      (clk),
    .rst      (rst),
    .smp      (smp),
    .busy_q   (busy),
    .xfer_q   (xfer_pulse),
    .done_q   (phase_done),
    .ev_start (ev_start),
    .ev_xfer  (ev_xfer),
    .ev_err   (ev_err)
  );

  bus_mon_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .start (ev_start),
    .xfer  (ev_xfer),
    .cnt_q (xfer_count)
  );

  bus_mon_errors u_err (
    .clk    (clk),
    .rst    (rst),
    .clr    (err_clr),
    .ev_err (ev_err),
    .err_q  (err_vec)
  );

  assign err_irdy_linger = err_vec[ERR_LINGER];
  assign err_frame_drop  = err_vec[ERR_DROP];
  assign err_trdy_extend = err_vec[ERR_EXTEND];
  assign err_stop_drop   = err_vec[ERR_STOPRL];

endmodule

// File: rtl/bus_mon_chk.sv
module bus_mon_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             err_clr,
  input logic             frame_n,
  input logic             irdy_n,
  input logic             busy,
  input logic             xfer_pulse,
  input logic             phase_done,
  input logic [CNT_W-1:0] xfer_count,
  input logic [3:0]       errs
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  busy_close_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> ($past(frame_n) && $past(irdy_n)));

  // R3
  xfer_is_done_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_pulse |-> phase_done);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !xfer_pulse && !$past(rst)) |-> $stable(xfer_count));

  // R4
  done_in_txn_chk: assert property (@(posedge clk) disable iff (rst)
    phase_done |-> busy);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(err_clr) && !$past(rst)) |-> (($past(errs) & ~errs) == 4'b0));

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && busy && $past(busy) && $past(xfer_count) == CNT_MAX)
      |-> xfer_count == CNT_MAX);

endmodule

bind bus_txn_monitor bus_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .err_clr    (err_clr),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .busy       (busy),
  .xfer_pulse (xfer_pulse),
  .phase_done (phase_done),
  .xfer_count (xfer_count),
  .errs       ({err_stop_drop, err_trdy_extend, err_frame_drop, err_irdy_linger})
);

// File: tb/bus_txn_monitor_tb.sv
`timescale 1ns/1ps
module bus_txn_monitor_tb;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_clr = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic busy, xfer_pulse, phase_done;
  logic [CNT_W-1:0] xfer_count;
  logic e_lin, e_drop, e_ext, e_stp;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_txn_monitor #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .err_clr(err_clr),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .busy(busy), .xfer_pulse(xfer_pulse), .phase_done(phase_done),
    .xfer_count(xfer_count),
    .err_irdy_linger(e_lin), .err_frame_drop(e_drop),
    .err_trdy_extend(e_ext), .err_stop_drop(e_stp)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one clock in positive logic, then land on the next falling
  // edge so outputs reflect this sample.
  task automatic step(input logic f, input logic i, input logic t, input logic s,
                      input logic c = 1'b0);
    frame_n = ~f; irdy_n = ~i; trdy_n = ~t; stop_n = ~s; err_clr = c;
    @(posedge clk);
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  function automatic int errs_now();
    return {e_stp, e_ext, e_drop, e_lin};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step(0, 0, 0, 0);
    rst = 1'b0;
    chk("R1", "busy", busy, 0);
    chk("R1", "count", xfer_count, 0);
    chk("R1", "errors", errs_now(), 0);
    chk("R1", "pulses", {xfer_pulse, phase_done}, 0);
  endtask

  task automatic t_burst();
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R2", "busy after open", busy, 1);
    chk("R4", "no done on address", phase_done, 0);
    for (int k = 1; k <= 3; k++) begin
      step(1, 1, 1, 0);
      chk("R3", "xfer pulse", xfer_pulse, 1);
      chk("R3", "count", xfer_count, k);
    end
    step(0, 1, 1, 0);
    chk("R4", "final done", phase_done, 1);
    chk("R3", "count 4", xfer_count, 4);
    step(0, 0, 0, 0);
    chk("R2", "busy after close", busy, 0);
    chk("R3", "count holds", xfer_count, 4);
    chk("R3", "no pulse idle", xfer_pulse, 0);
    chk("R5", "clean burst no errors", errs_now(), 0);
  endtask

  task automatic t_disconnect();
    step(1, 0, 0, 0);
    repeat (3) step(1, 1, 1, 0);
    step(1, 1, 0, 1);
    chk("R4", "stop ends phase", phase_done, 1);
    chk("R3", "stop no data", xfer_pulse, 0);
    chk("R3", "count 3", xfer_count, 3);
    step(0, 1, 0, 1);
    chk("R4", "last stop phase", phase_done, 1);
    step(0, 0, 0, 0);
    chk("R8", "clean disconnect", errs_now(), 0);
  endtask

  task automatic t_extend();
    step(1, 0, 0, 0);
    repeat (2) step(1, 1, 1, 0);
    step(1, 1, 1, 1);
    chk("R4", "stop+data done", phase_done, 1);
    chk("R7", "no ext yet", e_ext, 0);
    step(0, 1, 1, 1);
    chk("R7", "ext flagged", e_ext, 1);
    chk("R3", "extended word counted", xfer_count, 4);
    step(0, 0, 0, 0);
    chk("R7", "only ext", errs_now(), 4);
    step(0, 0, 0, 0, 1);
    chk("R9", "clear", errs_now(), 0);
  endtask

  task automatic t_stop_release();
    step(1, 0, 0, 0);
    step(1, 1, 0, 1);
    chk("R8", "held ok", e_stp, 0);
    step(1, 1, 0, 0);
    chk("R4", "irdy alone ends phase", phase_done, 1);
    chk("R8", "release flagged", e_stp, 1);
    step(0, 0, 0, 0);
    chk("R8", "only stop flag", errs_now(), 8);
    step(0, 0, 0, 0, 1);
  endtask

  task automatic t_linger();
    step(1, 0, 0, 0);
    step(1, 1, 1, 0);
    step(0, 1, 1, 0);
    chk("R5", "not yet", e_lin, 0);
    step(0, 1, 0, 0);
    chk("R5", "linger flagged", e_lin, 1);
    chk("R4", "no phase", phase_done, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R9", "sticky idle", e_lin, 1);
    step(1, 0, 0, 0);
    step(0, 1, 1, 0);
    step(0, 0, 0, 0);
    chk("R9", "sticky after clean", errs_now(), 1);
    step(0, 0, 0, 0, 1);
    chk("R9", "cleared", errs_now(), 0);
  endtask

  task automatic t_frame_drop();
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    chk("R6", "wait no flag", e_drop, 0);
    step(0, 1, 0, 0);
    chk("R6", "drop flagged", e_drop, 1);
    step(0, 1, 1, 0);
    chk("R4", "final done", phase_done, 1);
    step(0, 0, 0, 0);
    chk("R6", "only drop", errs_now(), 2);
    step(0, 0, 0, 0, 1);
  endtask

  task automatic t_saturate();
    step(1, 0, 0, 0);
    repeat (260) step(1, 1, 1, 0);
    chk("R10", "saturated", xfer_count, 255);
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R3", "restart on open", xfer_count, 0);
    step(0, 0, 0, 0);
  endtask

  task automatic t_idle_noise();
    step(0, 0, 1, 1);
    chk("R2", "idle ignores", {busy, xfer_pulse, phase_done}, 0);
    chk("R2", "idle no errors", errs_now(), 0);
    chk("R2", "count untouched", xfer_count, 0);
  endtask

  task automatic t_reset_mid();
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    step(0, 1, 0, 0);
    chk("R6", "set before reset", e_drop, 1);
    do_reset();
  endtask

  task automatic run_all();
    do_reset();
    t_burst();
    t_disconnect();
    t_extend();
    t_stop_release();
    t_linger();
    t_frame_drop();
    t_saturate();
    t_idle_noise();
    t_reset_mid();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule